// File: doc/BRIEF.md
# Instruction Prefetch Queue with Deferred Bus Faults

The block fetches 16-bit instruction words ahead of the execution side and keeps them in a small first-in first-out queue. It issues word-sized fetch requests at consecutive addresses through a valid/ready request port. Responses come back in order on a separate port, and each response carries an error bit. The error bit is not acted on when the response arrives. It is stored as a tag next to the word, so a fetch error is raised only if the execution side actually consumes that word.

Decode reads the head of the queue and pops it. A clean head word is offered with a valid strobe. A tagged head word is never offered as data. Popping it raises a fault strobe in that same cycle, and the exception logic outside the block then takes over. A branch or a task switch drives the flush input together with the new fetch address. The flush empties the queue in one cycle and drops all stored tags. Responses that were already in flight at the flush are counted and discarded when they arrive, so a stale word or a stale fault never reaches decode.

Top module: `pfq_prefetch_queue`

## Requirements
- R1: While reset is asserted and until the synchronised reset has been released, req_valid, dec_valid and dec_fault are 0. The first request after reset uses address RESET_ADDR (default 0x000100) and the queue starts empty.
- R2: Each accepted request (req_valid and req_ready high, no flush) advances req_addr by 2 in the next cycle. While a request is not accepted, req_addr holds its value.
- R3: req_valid is high only when the number of free queue entries (DEPTH minus stored words, DEPTH = 4) is strictly greater than the number of live outstanding requests. A full queue, or a queue whose free entries are all claimed by requests in flight, issues nothing.
- R4: req_valid stays low while the total number of requests in flight, discarded ones included, equals MAX_INFL (default 8).
- R5: Kept responses are stored in arrival order. When the head entry is untagged, dec_valid is 1 and dec_data is that word; a pop advances to the next word in the following cycle.
- R6: A response with rsp_err = 1 is stored with a fault tag. While a tagged word is at the head, dec_valid is 0. dec_fault is 1 only in a cycle where dec_pop is high with that tagged word at the head, and the pop removes it.
- R7: In a flush cycle req_valid is 0 and dec_pop is ignored. In the next cycle the queue is empty (dec_valid = 0) and req_addr equals the flush_addr given in the flush cycle.
- R8: Every response that was in flight at a flush is discarded, including one that arrives in the flush cycle itself, and neither its data nor its error bit reaches decode. Responses to requests issued after the flush are stored normally.
- R9: dec_pop on an empty queue has no effect on the queue state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Branch or task switch: empty the queue and redirect fetching |
| flush_addr | input | ADDR_W (24) | New fetch address, used in a flush cycle |
| req_valid | output | 1 | Fetch request pending |
| req_ready | input | 1 | Bus accepts the request this cycle |
| req_addr | output | ADDR_W (24) | Byte address of the requested word |
| rsp_valid | input | 1 | A fetch response arrives, in request order |
| rsp_data | input | 16 | Fetched instruction word |
| rsp_err | input | 1 | The fetch ended in a bus error |
| dec_pop | input | 1 | Decode consumes the head entry |
| dec_valid | output | 1 | Head entry holds a clean word |
| dec_data | output | 16 | Head word |
| dec_fault | output | 1 | The entry popped this cycle carries a fault tag |

## Verification
req_valid, req_addr, dec_valid and dec_data are decoded directly from registered state, and dec_fault is also decoded from the current dec_pop. All of them are therefore valid in the same cycle as the inputs that drive them. A response, pop, accepted request or flush changes these outputs one clock edge later. The bench drives its inputs on the falling edge and samples 2 ns afterwards, so each check sees the state left by the previous rising edge together with the inputs of the current cycle. The expected values in the vector table and in the directed tests are worked out cycle by cycle from that rule. The synchroniser adds three rising edges between reset release and the first request, and the bench waits through them before it starts stepping.

// File: rtl/pfq_pkg.sv
`timescale 1ns/1ps
package pfq_pkg;
  localparam int unsigned PFQ_WORD_W = 16;

  typedef struct packed {
    logic                  tag;
    logic [PFQ_WORD_W-1:0] word;
  } pfq_entry_t;
endpackage

// File: rtl/pfq_store.sv
`timescale 1ns/1ps
// Tagged word FIFO; DEPTH must be a power of two (pointers wrap naturally).
module pfq_store #(
  parameter int unsigned DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wr_en,
  input  pfq_pkg::pfq_entry_t          wr_entry,
  input  logic                         rd_req,
  output pfq_pkg::pfq_entry_t          head,
  output logic [$clog2(DEPTH+1)-1:0]   occ,
  output logic                         empty
);
  import pfq_pkg::*;

  localparam int unsigned PW    = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [PW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] occ_q, occ_d;
  logic             rd_fire;
  logic             ptr_en;
  pfq_entry_t       slot_w [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      pfq_entry_t slot_r;
      logic       slot_en;
      assign slot_en = wr_en && (wr_ptr_q == PW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       slot_r <= '0;
        else if (slot_en) slot_r <= wr_entry;
      end
      assign slot_w[g] = slot_r;
    end
  endgenerate

  assign empty   = (occ_q == '0);
  assign occ     = occ_q;
  assign head    = slot_w[rd_ptr_q];
  assign rd_fire = rd_req && !flush && !empty;
  assign ptr_en  = flush || wr_en || rd_fire;

  always_comb begin
    wr_ptr_d = wr_en ? wr_ptr_q + 1'b1 : wr_ptr_q;
    if (flush)        rd_ptr_d = wr_ptr_q;
    else if (rd_fire) rd_ptr_d = rd_ptr_q + 1'b1;
    else              rd_ptr_d = rd_ptr_q;
    if (flush) begin
      occ_d = '0;
    end else begin
      occ_d = occ_q;
      if (wr_en && !rd_fire)      occ_d = occ_q + 1'b1;
      else if (!wr_en && rd_fire) occ_d = occ_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (occ_q != CNT_W'(DEPTH))); // R3
  AST_OCC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CNT_W'(DEPTH)); // R5
  AST_NO_WRITE_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !wr_en); // R8
endmodule

// File: rtl/pfq_fetch_ctl.sv
`timescale 1ns/1ps
module pfq_fetch_ctl #(
  parameter int unsigned          DEPTH      = 4,
  parameter int unsigned          ADDR_W     = 24,
  parameter logic [ADDR_W-1:0]    RESET_ADDR = 24'h000100,
  parameter int unsigned          MAX_INFL   = 2*DEPTH
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [ADDR_W-1:0]           flush_addr,
  input  logic [$clog2(DEPTH+1)-1:0]  occ,
  input  logic                        req_ready,
  input  logic                        rsp_valid,
  output logic                        req_valid,
  output logic [ADDR_W-1:0]           req_addr,
  output logic                        rsp_keep
);
  localparam int unsigned IW    = $clog2(MAX_INFL+1);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam int unsigned SW    = ((IW > CNT_W) ? IW : CNT_W) + 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(pfq_pkg::PFQ_WORD_W / 8);

  logic              run_q;
  logic [IW-1:0]     infl_q, infl_d;
  logic [IW-1:0]     drop_q, drop_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [SW-1:0]     free_w, live_w;
  logic              issue;
  logic              cnt_en, pc_en;

  always_comb begin
    free_w    = SW'(DEPTH) - SW'(occ);
    live_w    = SW'(infl_q) - SW'(drop_q);
    req_valid = run_q && !flush && (free_w > live_w) && (infl_q < IW'(MAX_INFL));
  end

  assign issue    = req_valid && req_ready;
  assign rsp_keep = rsp_valid && !flush && (drop_q == '0);
  assign req_addr = pc_q;
  assign cnt_en   = issue || rsp_valid || flush;
  assign pc_en    = issue || flush;

  always_comb begin
    infl_d = infl_q;
    if (issue && !rsp_valid)      infl_d = infl_q + 1'b1;
    else if (!issue && rsp_valid) infl_d = infl_q - 1'b1;
    drop_d = drop_q;
    if (flush)                           drop_d = infl_d;
    else if (rsp_valid && drop_q != '0)  drop_d = drop_q - 1'b1;
    if (flush) pc_d = flush_addr;
    else       pc_d = pc_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      infl_q <= '0;
      drop_q <= '0;
    end else if (cnt_en) begin
      infl_q <= infl_d;
      drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_ADDR;
    else if (pc_en) pc_q <= pc_d;
  end

  AST_INFL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    infl_q <= IW'(MAX_INFL)); // R4
  AST_DROP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q <= infl_q); // R8
  AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (infl_q != '0)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !flush) |=> (req_addr == $past(req_addr) + STEP)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && !flush) |=> $stable(req_addr)); // R2
  AST_FLUSH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (req_addr == $past(flush_addr))); // R7
endmodule

// File: rtl/pfq_prefetch_queue.sv
`timescale 1ns/1ps
module pfq_prefetch_queue #(
  parameter int unsigned       DEPTH      = 4,
  parameter int unsigned       ADDR_W     = 24,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 24'h000100,
  parameter int unsigned       MAX_INFL   = 2*DEPTH
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic [ADDR_W-1:0]              flush_addr,
  output logic                           req_valid,
  input  logic                           req_ready,
  output logic [ADDR_W-1:0]              req_addr,
  input  logic                           rsp_valid,
  input  logic [pfq_pkg::PFQ_WORD_W-1:0] rsp_data,
  input  logic                           rsp_err,
  input  logic                           dec_pop,
  output logic                           dec_valid,
  output logic [pfq_pkg::PFQ_WORD_W-1:0] dec_data,
  output logic                           dec_fault
);
  import pfq_pkg::*;

  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [1:0]       rs_q;
  logic             srst_n;
  logic [CNT_W-1:0] occ;
  logic             empty;
  logic             keep;
  pfq_entry_t       wr_entry;
  pfq_entry_t       head;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  assign wr_entry.tag  = rsp_err;
  assign wr_entry.word = rsp_data;

  pfq_fetch_ctl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR), .MAX_INFL(MAX_INFL)
  ) u_fetch (
    .clk(clk), .rst_n(srst_n), .flush(flush), .flush_addr(flush_addr),
    .occ(occ), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_keep(keep)
  );

  pfq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(srst_n), .flush(flush), .wr_en(keep),
    .wr_entry(wr_entry), .rd_req(dec_pop),
    .head(head), .occ(occ), .empty(empty)
  );

  assign dec_valid = !empty && !head.tag;
  assign dec_data  = head.word;
  assign dec_fault = !empty && head.tag && dec_pop && !flush;

  AST_FAULT_CONSUMES: assert property (@(posedge clk) disable iff (!srst_n)
    dec_fault |=> (occ == CNT_W'($past(occ) + CNT_W'($past(keep)) - CNT_W'(1)))); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!srst_n)
    flush |=> !dec_valid); // R7
endmodule

// File: tb/tb_pfq_prefetch_queue.sv
`timescale 1ns/1ps
module tb_pfq_prefetch_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic [23:0] flush_addr;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_addr;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        rsp_err;
  logic        dec_pop;
  logic        dec_valid;
  logic [15:0] dec_data;
  logic        dec_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pfq_prefetch_queue dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .dec_pop(dec_pop), .dec_valid(dec_valid), .dec_data(dec_data),
    .dec_fault(dec_fault)
  );

  typedef struct packed {
    logic        fl;
    logic [23:0] fa;
    logic        rdy;
    logic        rv;
    logic        re;
    logic [15:0] rd;
    logic        pop;
    logic        erq;
    logic [23:0] ea;
    logic        edv;
    logic        edf;
    logic [15:0] ed;
  } row_t;

  // inputs: flush, flush_addr, ready, rsp_valid, rsp_err, rsp_data, pop
  // expected: req_valid, req_addr, dec_valid, dec_fault, dec_data
  localparam row_t TBL [17] = '{
    '{1'b0, 24'h0,   1'b1, 1'b0, 1'b0, 16'h0,    1'b0, 1'b1, 24'h100, 1'b0, 1'b0, 16'h0},
    '{1'b0, 24'h0,   1'b1, 1'b0, 1'b0, 16'h0,    1'b0, 1'b1, 24'h102, 1'b0, 1'b0, 16'h0},
    '{1'b0, 24'h0,   1'b1, 1'b1, 1'b0, 16'h1111, 1'b0, 1'b1, 24'h104, 1'b0, 1'b0, 16'h0},
    '{1'b0, 24'h0,   1'b1, 1'b1, 1'b1, 16'h2222, 1'b0, 1'b1, 24'h106, 1'b1, 1'b0, 16'h1111},
    '{1'b0, 24'h0,   1'b1, 1'b1, 1'b0, 16'h3333, 1'b0, 1'b0, 24'h0,   1'b1, 1'b0, 16'h1111},
    '{1'b0, 24'h0,   1'b1, 1'b0, 1'b0, 16'h0,    1'b1, 1'b0, 24'h0,   1'b1, 1'b0, 16'h1111},
    '{1'b0, 24'h0,   1'b0, 1'b0, 1'b0, 16'h0,    1'b0, 1'b1, 24'h108, 1'b0, 1'b0, 16'h0},
    '{1'b0, 24'h0,   1'b0, 1'b0, 1'b0, 16'h0,    1'b1, 1'b1, 24'h108, 1'b0, 1'b1, 16'h0},
    '{1'b0, 24'h0,   1'b0, 1'b0, 1'b0, 16'h0,    1'b0, 1'b1, 24'h108, 1'b1, 1'b0, 16'h3333},
    '{1'b0, 24'h0,   1'b0, 1'b1, 1'b1, 16'h4444, 1'b0, 1'b1, 24'h108, 1'b1, 1'b0, 16'h3333},
    '{1'b1, 24'h200, 1'b1, 1'b0, 1'b0, 16'h0,    1'b1, 1'b0, 24'h0,   1'b1, 1'b0, 16'h3333},
    '{1'b0, 24'h0,   1'b1, 1'b0, 1'b0, 16'h0,    1'b0, 1'b1, 24'h200, 1'b0, 1'b0, 16'h0},
    '{1'b0, 24'h0,   1'b1, 1'b0, 1'b0, 16'h0,    1'b1, 1'b1, 24'h202, 1'b0, 1'b0, 16'h0},
    '{1'b1, 24'h300, 1'b1, 1'b1, 1'b0, 16'h5555, 1'b0, 1'b0, 24'h0,   1'b0, 1'b0, 16'h0},
    '{1'b0, 24'h0,   1'b1, 1'b1, 1'b1, 16'h6666, 1'b0, 1'b1, 24'h300, 1'b0, 1'b0, 16'h0},
    '{1'b0, 24'h0,   1'b0, 1'b1, 1'b0, 16'h7777, 1'b0, 1'b1, 24'h302, 1'b0, 1'b0, 16'h0},
    '{1'b0, 24'h0,   1'b0, 1'b0, 1'b0, 16'h0,    1'b0, 1'b1, 24'h302, 1'b1, 1'b0, 16'h7777}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic [23:0] fa, input logic rdy,
                       input logic rv, input logic re, input logic [15:0] rd,
                       input logic pop);
    @(negedge clk);
    flush = f; flush_addr = fa; req_ready = rdy;
    rsp_valid = rv; rsp_err = re; rsp_data = rd; dec_pop = pop;
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    flush = 1'b0; flush_addr = '0; req_ready = 1'b0;
    rsp_valid = 1'b0; rsp_err = 1'b0; rsp_data = '0; dec_pop = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(req_valid, 0, "R1 req_valid in reset");
    chk(dec_valid, 0, "R1 dec_valid in reset");
    chk(dec_fault, 0, "R1 dec_fault in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(req_valid, 0, "R1 req_valid at release");
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    do_reset();

    // Vector table walk
    for (int i = 0; i < 17; i++) begin
      drive(TBL[i].fl, TBL[i].fa, TBL[i].rdy, TBL[i].rv, TBL[i].re, TBL[i].rd, TBL[i].pop);
      chk(req_valid, TBL[i].erq, $sformatf("R3 req_valid row %0d", i));
      if (TBL[i].erq) chk(req_addr, TBL[i].ea, $sformatf("R2 req_addr row %0d", i));
      chk(dec_valid, TBL[i].edv, $sformatf("R5 dec_valid row %0d", i));
      chk(dec_fault, TBL[i].edf, $sformatf("R6 dec_fault row %0d", i));
      if (TBL[i].edv) chk(dec_data, TBL[i].ed, $sformatf("R5 dec_data row %0d", i));
    end

    // Queue fully claimed by outstanding requests, then filled, then drained
    do_reset();
    chk(req_addr, 24'h100, "R1 first address");
    for (int i = 0; i < 4; i++) begin
      drive(0, 0, 1, 0, 0, 0, 0);
      chk(req_valid, 1, "R3 issue while free > live");
    end
    drive(0, 0, 1, 0, 0, 0, 0);
    chk(req_valid, 0, "R3 no issue with all entries claimed");
    for (int i = 0; i < 4; i++) begin
      drive(0, 0, 1, 1, (i == 2), 16'hA0 + 16'(i), 0);
      chk(req_valid, 0, "R3 no issue while filling");
    end
    drive(0, 0, 0, 0, 0, 0, 1);
    chk(req_valid, 0, "R3 full queue issues nothing");
    chk(dec_valid, 1, "R5 head valid");
    chk(dec_data, 16'hA0, "R5 first word");
    drive(0, 0, 0, 0, 0, 0, 1);
    chk(dec_data, 16'hA1, "R5 second word");
    chk(req_valid, 1, "R3 issue after pop frees entry");
    chk(req_addr, 24'h108, "R2 address after four");
    drive(0, 0, 0, 0, 0, 0, 1);
    chk(dec_valid, 0, "R6 tagged head not valid");
    chk(dec_fault, 1, "R6 fault on pop of tagged word");
    drive(0, 0, 0, 0, 0, 0, 1);
    chk(dec_fault, 0, "R6 fault consumed");
    chk(dec_data, 16'hA3, "R5 word after fault");
    drive(0, 0, 0, 0, 0, 0, 1);
    chk(dec_valid, 0, "R9 empty after drain");
    drive(0, 0, 0, 0, 0, 0, 0);
    chk(dec_valid, 0, "R9 pop on empty has no effect");
    chk(dec_fault, 0, "R9 no fault on empty pop");

    // In-flight cap and discard of stale responses
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 0, 0, 0, 0);
    drive(1, 24'h400, 1, 0, 0, 0, 0);
    chk(req_valid, 0, "R7 no request in flush cycle");
    drive(0, 0, 1, 0, 0, 0, 0);
    chk(req_addr, 24'h400, "R7 redirect address");
    chk(req_valid, 1, "R8 stale requests do not block");
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0, 0, 0);
    drive(1, 24'h500, 1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0, 0);
    chk(req_valid, 0, "R4 cap of in-flight requests");
    drive(0, 0, 1, 1, 1, 16'hBEEF, 0);
    chk(req_valid, 0, "R4 still at cap");
    drive(0, 0, 0, 0, 0, 0, 0);
    chk(req_valid, 1, "R4 issue below cap");
    chk(req_addr, 24'h500, "R7 second redirect address");
    chk(dec_valid, 0, "R8 stale response dropped");
    chk(dec_fault, 0, "R8 stale error dropped");
    for (int i = 0; i < 7; i++) begin
      drive(0, 0, 0, 1, (i == 3), 16'hDEAD, 1);
      chk(dec_valid, 0, "R8 stale data never offered");
      chk(dec_fault, 0, "R8 stale fault never raised");
    end
    drive(0, 0, 1, 0, 0, 0, 0);
    chk(dec_valid, 0, "R8 queue empty after stale drain");
    drive(0, 0, 0, 1, 0, 16'h1234, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk(dec_valid, 1, "R8 fresh response kept");
    chk(dec_data, 16'h1234, "R8 fresh data");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule